// File: doc/BRIEF.md
# Adapter and Battery Power-Source Selector

This controller decides, once per clock, whether the system rail is fed from an external adapter or from the battery. It works on comparator results that are already digital. Those results say whether the adapter-detect voltage is above the reset level, the valid level and the overvoltage level. They also say whether the supply is above its undervoltage lockout, whether the supply clears the battery node by the required margin, whether the battery node is above its own lockout, and whether the input node sits close to the battery. A 1 ms tick paces the qualification delay. An option input picks between the long and short delays once the controller has a qualification history.

The adapter is accepted only after its conditions have held for a qualification period. That period depends on history. The first acceptance after power-on is short. A detect-reset event forces the next one long. Once the adapter has been properly removed, the option input picks the delay. Any loss of a condition drops the adapter-OK flag at the next edge. Changing source passes through a parameterised gap in which neither switch is enabled. The charge-enable output follows adapter-OK only while the adapter switch pair is closed.

Top module: `pwr_src_sel`

## Requirements
- R1: `adapter_ok` is high only if, at the previous edge, all five adapter conditions held: `vcc_uvlo_ok`, `det_above_rst`, `det_above_valid`, `vcc_over_bat`, and `det_above_ovp` low. Losing any of them clears `adapter_ok` at the next edge.
- R2: The first qualification after reset takes exactly SHORT_MS (150) ticks, whatever the value of `opt_long`.
- R3: A qualification is "armed" when, since the previous acceptance, `det_above_valid` was seen low and the adapter pair was switched off. An armed qualification takes LONG_MS (1300) ticks when `opt_long`=1 and SHORT_MS ticks when `opt_long`=0.
- R4: A requalification that is not armed, and not forced long, takes SHORT_MS ticks even when `opt_long`=1.
- R5: After `det_above_rst` has been low, `adapter_ok` is cleared and the next qualification takes LONG_MS ticks even when `opt_long`=0.
- R6: The delay counter advances only on cycles with `tick_ms` high. With no ticks the adapter is never accepted. A one-cycle loss of any condition restarts the full count.
- R7: When `det_above_ovp` rises, `adapter_ok`, `adp_sw_en` and `chg_en` fall. If the battery conditions hold, `bat_sw_en` rises after the gap. When the detect input returns to the window, the adapter is accepted again and replaces the battery.
- R8: `bat_sw_en` is high only if, at the previous edge, `vcc_uvlo_ok`, `bat_uvlo_ok` and `acn_near_bat` all held and `adapter_ok` did not replace the battery. When reset is released with these conditions true, the battery connects one cycle later.
- R9: `adp_sw_en` and `bat_sw_en` are never high together. At each changeover both are low for exactly GAP_CYC (2) cycles.
- R10: `chg_en` is high exactly while `adapter_ok` and `adp_sw_en` are both high.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| det_above_rst | input | 1 | Detect voltage above the reset level |
| det_above_valid | input | 1 | Detect voltage above the valid level |
| det_above_ovp | input | 1 | Detect voltage above the overvoltage level |
| vcc_uvlo_ok | input | 1 | Supply above undervoltage lockout |
| vcc_over_bat | input | 1 | Supply exceeds battery node by the required margin |
| bat_uvlo_ok | input | 1 | Battery node above undervoltage lockout |
| acn_near_bat | input | 1 | Input node within the small margin above the battery |
| opt_long | input | 1 | 1 selects the long delay for armed qualifications |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| adapter_ok | output | 1 | Adapter qualified |
| adp_sw_en | output | 1 | Enable for the adapter-side switch pair |
| bat_sw_en | output | 1 | Enable for the battery switch |
| chg_en | output | 1 | Charging permitted |

## Verification
On every cycle the assertions check several properties. The two switch enables never overlap, and each falling enable is followed by a cycle with the other still low. Adapter-OK and the battery switch are only ever backed by their conditions on the previous edge, and adapter-OK only rises on a tick. The history-dependent delay needs the bench's scenarios. The scenarios show that the first, unarmed, armed-long, armed-short and forced-long delays take 150, 150, 1300, 150 and 1300 ticks. They also cover the restart after a glitch, the exact length of the gap, and the hand-over through an overvoltage episode.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_BAT,
    SRC_GAP_ADP,
    SRC_ADP,
    SRC_GAP_BAT
  } src_state_t;

  typedef enum logic {DLY_SHORT, DLY_LONG} dly_sel_t;

  // Delay choice from qualification history, highest priority first.
  function automatic dly_sel_t pick_delay(input logic first_done,
                                          input logic force_long,
                                          input logic armed,
                                          input logic opt_long);
    if (!first_done)               return DLY_SHORT;
    else if (force_long)           return DLY_LONG;
    else if (armed && opt_long)    return DLY_LONG;
    else                           return DLY_SHORT;
  endfunction

  function automatic logic adapter_window(input logic vcc_ok,
                                          input logic above_rst,
                                          input logic above_valid,
                                          input logic above_ovp,
                                          input logic margin);
    return vcc_ok && above_rst && above_valid && !above_ovp && margin;
  endfunction

  function automatic logic battery_path(input logic vcc_ok,
                                        input logic bat_ok,
                                        input logic near);
    return vcc_ok && bat_ok && near;
  endfunction

endpackage

// File: rtl/pss_qual.sv
module pss_qual
  import pss_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int LONG_MS  = 1300
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cond_ok,
  input  logic     det_above_rst,
  input  logic     det_above_valid,
  input  logic     opt_long,
  input  logic     tick_ms,
  input  logic     pair_off_evt,
  output logic     adapter_ok,
  output logic     qual_evt,
  output dly_sel_t dly_sel
);
  localparam int MAXV  = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0] cnt, tgt;
  logic first_done, force_long, fell_seen, off_seen, armed;

  assign armed   = fell_seen && off_seen;
  assign dly_sel = pick_delay(first_done, force_long, armed, opt_long);
  assign tgt     = (dly_sel == DLY_LONG) ? CNT_W'(LONG_MS - 1) : CNT_W'(SHORT_MS - 1);
  assign qual_evt = cond_ok && !adapter_ok && tick_ms && (cnt == tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      adapter_ok <= 1'b0;
      first_done <= 1'b0;
      force_long <= 1'b0;
      fell_seen  <= 1'b0;
      off_seen   <= 1'b0;
    end else begin
      if (!det_above_rst)   force_long <= 1'b1;
      if (!det_above_valid) fell_seen  <= 1'b1;
      if (pair_off_evt)     off_seen   <= 1'b1;
      if (!cond_ok) begin
        adapter_ok <= 1'b0;
        cnt        <= '0;
      end else if (qual_evt) begin
        adapter_ok <= 1'b1;
        cnt        <= '0;
        first_done <= 1'b1;
        force_long <= 1'b0;
        fell_seen  <= 1'b0;
        off_seen   <= 1'b0;
      end else if (!adapter_ok && tick_ms) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_bbm.sv
module pss_bbm
  import pss_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adapter_ok,
  input  logic bat_ok,
  output logic adp_en,
  output logic bat_en,
  output logic pair_off_evt
);
  localparam int GW = $clog2(GAP_CYC + 1);

  src_state_t state, nxt;
  logic [GW-1:0] gcnt;
  logic in_gap, gap_done;

  assign in_gap   = (state == SRC_GAP_ADP) || (state == SRC_GAP_BAT);
  assign gap_done = in_gap && (gcnt == GW'(GAP_CYC - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      SRC_NONE:    if (adapter_ok) nxt = SRC_ADP;
                   else if (bat_ok) nxt = SRC_BAT;
      SRC_BAT:     if (adapter_ok) nxt = SRC_GAP_ADP;
                   else if (!bat_ok) nxt = SRC_NONE;
      SRC_ADP:     if (!adapter_ok) nxt = SRC_GAP_BAT;
      SRC_GAP_ADP,
      SRC_GAP_BAT: if (gap_done)
                     nxt = adapter_ok ? SRC_ADP : (bat_ok ? SRC_BAT : SRC_NONE);
      default:     nxt = SRC_NONE;
    endcase
  end

  assign pair_off_evt = (state == SRC_ADP) && (nxt != SRC_ADP);
  assign adp_en       = (state == SRC_ADP);
  assign bat_en       = (state == SRC_BAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SRC_NONE;
      gcnt  <= '0;
    end else begin
      state <= nxt;
      gcnt  <= (in_gap && !gap_done) ? gcnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pwr_src_sel.sv
module pwr_src_sel
  import pss_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int LONG_MS  = 1300,
  parameter int GAP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_above_rst,
  input  logic det_above_valid,
  input  logic det_above_ovp,
  input  logic vcc_uvlo_ok,
  input  logic vcc_over_bat,
  input  logic bat_uvlo_ok,
  input  logic acn_near_bat,
  input  logic opt_long,
  input  logic tick_ms,
  output logic adapter_ok,
  output logic adp_sw_en,
  output logic bat_sw_en,
  output logic chg_en
);
  logic     cond_ok, bat_ok, pair_off_evt, qual_evt;
  dly_sel_t dly_sel;

  assign cond_ok = adapter_window(vcc_uvlo_ok, det_above_rst, det_above_valid,
                                  det_above_ovp, vcc_over_bat);
  assign bat_ok  = battery_path(vcc_uvlo_ok, bat_uvlo_ok, acn_near_bat);

  pss_qual #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_qual (
    .clk             (clk),
    .rst_n           (rst_n),
    .cond_ok         (cond_ok),
    .det_above_rst   (det_above_rst),
    .det_above_valid (det_above_valid),
    .opt_long        (opt_long),
    .tick_ms         (tick_ms),
    .pair_off_evt    (pair_off_evt),
    .adapter_ok      (adapter_ok),
    .qual_evt        (qual_evt),
    .dly_sel         (dly_sel)
  );

  pss_bbm #(.GAP_CYC(GAP_CYC)) u_bbm (
    .clk          (clk),
    .rst_n        (rst_n),
    .adapter_ok   (adapter_ok),
    .bat_ok       (bat_ok),
    .adp_en       (adp_sw_en),
    .bat_en       (bat_sw_en),
    .pair_off_evt (pair_off_evt)
  );

  assign chg_en = adapter_ok && adp_sw_en;
endmodule

// File: rtl/pss_chk.sv
module pss_chk (
  input logic clk,
  input logic rst_n,
  input logic det_above_rst,
  input logic det_above_valid,
  input logic det_above_ovp,
  input logic vcc_uvlo_ok,
  input logic vcc_over_bat,
  input logic bat_uvlo_ok,
  input logic acn_near_bat,
  input logic tick_ms,
  input logic adapter_ok,
  input logic adp_sw_en,
  input logic bat_sw_en
);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(adp_sw_en && bat_sw_en));

  a_r9_gap_after_bat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_sw_en) |=> !adp_sw_en);

  a_r9_gap_after_adp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adp_sw_en) |=> !bat_sw_en);

  a_r1_ok_backed: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_ok |-> $past(vcc_uvlo_ok && det_above_rst && det_above_valid &&
                         !det_above_ovp && vcc_over_bat));

  a_r7_ovp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_above_ovp) |=> !adapter_ok);

  a_r8_bat_backed: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sw_en |-> $past(vcc_uvlo_ok && bat_uvlo_ok && acn_near_bat));

  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adapter_ok) |-> $past(tick_ms));
endmodule

bind pwr_src_sel pss_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .det_above_rst   (det_above_rst),
  .det_above_valid (det_above_valid),
  .det_above_ovp   (det_above_ovp),
  .vcc_uvlo_ok     (vcc_uvlo_ok),
  .vcc_over_bat    (vcc_over_bat),
  .bat_uvlo_ok     (bat_uvlo_ok),
  .acn_near_bat    (acn_near_bat),
  .tick_ms         (tick_ms),
  .adapter_ok      (adapter_ok),
  .adp_sw_en       (adp_sw_en),
  .bat_sw_en       (bat_sw_en)
);

// File: tb/test_pwr_src_sel.sv
`timescale 1ns/1ps
module test_pwr_src_sel;
  localparam int SHORT = 150;
  localparam int LONG  = 1300;
  localparam int GAP   = 2;

  logic clk = 1'b0;
  logic rst_n, d_rst, d_valid, d_ovp, vcc_ok, margin, bat_ok, near, opt_long, tick;
  logic adapter_ok, adp_sw_en, bat_sw_en, chg_en;
  int n_chk = 0, n_bad = 0, overlap = 0;

  always #5 clk = ~clk;

  pwr_src_sel #(.SHORT_MS(SHORT), .LONG_MS(LONG), .GAP_CYC(GAP)) i_pwr_src_sel (
    .clk(clk), .rst_n(rst_n), .det_above_rst(d_rst), .det_above_valid(d_valid),
    .det_above_ovp(d_ovp), .vcc_uvlo_ok(vcc_ok), .vcc_over_bat(margin),
    .bat_uvlo_ok(bat_ok), .acn_near_bat(near), .opt_long(opt_long), .tick_ms(tick),
    .adapter_ok(adapter_ok), .adp_sw_en(adp_sw_en), .bat_sw_en(bat_sw_en), .chg_en(chg_en)
  );

  always @(negedge clk) if (rst_n && adp_sw_en && bat_sw_en) overlap++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Count negedges from the current one until adapter_ok is seen high.
  task automatic measure(output int n);
    n = 0;
    while (!adapter_ok && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic qualify(input string req, input int exp);
    int n;
    measure(n);
    check(req, n, exp);
  endtask

  // Both enables low count before the adapter pair closes.
  task automatic check_gap_to_adp(input string req);
    int g = 0;
    while (!adp_sw_en && g < 20) begin
      @(negedge clk);
      if (!adp_sw_en && !bat_sw_en) g++;
    end
    check(req, g, GAP);
    check("R10 chg_en with pair closed", chg_en, 1);
  endtask

  task automatic drop_to_battery(input string req);
    @(negedge clk);
    check({req, " ok drops"}, adapter_ok, 0);
    check("R10 chg_en follows ok", chg_en, 0);
    repeat (GAP + 3) @(negedge clk);
    check({req, " battery reconnected"}, bat_sw_en, 1);
    check({req, " pair open"}, adp_sw_en, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; d_rst = 0; d_valid = 0; d_ovp = 0; vcc_ok = 1; margin = 0;
    bat_ok = 1; near = 1; opt_long = 1; tick = 1;
    repeat (4) @(negedge clk);
    check("R11 reset ok", adapter_ok, 0);
    check("R11 reset adp", adp_sw_en, 0);
    check("R11 reset bat", bat_sw_en, 0);
    check("R11 reset chg", chg_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 battery after reset", bat_sw_en, 1);
  endtask

  task automatic t_first();
    d_rst = 1; d_valid = 1; margin = 1; opt_long = 1;
    qualify("R2 first qualification short", SHORT);
    check_gap_to_adp("R9 gap battery to adapter");
    check("R9 battery off", bat_sw_en, 0);
  endtask

  task automatic t_unarmed();
    margin = 0;
    drop_to_battery("R1 margin loss");
    margin = 1;
    qualify("R4 unarmed requal short", SHORT);
    check_gap_to_adp("R9 gap again");
  endtask

  task automatic t_armed(input logic opt, input int exp, input string req);
    opt_long = opt;
    d_valid = 0;
    drop_to_battery("R3 valid loss");
    d_valid = 1;
    qualify(req, exp);
    check_gap_to_adp("R9 gap armed");
  endtask

  task automatic t_ovp();
    opt_long = 1;
    d_ovp = 1;
    drop_to_battery("R7 overvoltage");
    d_ovp = 0;
    qualify("R7 return from overvoltage", SHORT);
    check_gap_to_adp("R7 adapter restored");
  endtask

  task automatic t_detect_reset();
    opt_long = 0;
    d_rst = 0; d_valid = 0;
    drop_to_battery("R5 detect reset");
    d_rst = 1; d_valid = 1;
    qualify("R5 forced long", LONG);
    check_gap_to_adp("R9 gap after forced long");
  endtask

  task automatic t_ticks();
    margin = 0;
    drop_to_battery("R6 setup");
    tick = 0; margin = 1;
    repeat (400) @(negedge clk);
    check("R6 no ticks no accept", adapter_ok, 0);
    tick = 1;
    repeat (SHORT - 51) @(negedge clk);
    margin = 0;
    @(negedge clk);
    margin = 1;
    qualify("R6 glitch restarts count", SHORT);
    check_gap_to_adp("R9 gap after restart");
  endtask

  task automatic t_battery_and_uvlo();
    margin = 0;
    drop_to_battery("R8 setup");
    bat_ok = 0;
    @(negedge clk);
    check("R8 battery opens on lockout", bat_sw_en, 0);
    margin = 1; vcc_ok = 0;
    repeat (LONG + 50) @(negedge clk);
    check("R1 no accept under supply lockout", adapter_ok, 0);
    check("R8 battery stays open", bat_sw_en, 0);
  endtask

  initial begin
    t_reset();
    t_first();
    t_unarmed();
    t_armed(1'b1, LONG, "R3 armed long");
    t_armed(1'b0, SHORT, "R3 armed short");
    t_ovp();
    t_detect_reset();
    t_ticks();
    t_battery_and_uvlo();
    check("R9 enables never overlap", overlap, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule